// File: doc/BRIEF.md
# Span Z/Color Interpolator with Depth Test

This block rasterizes one horizontal span at a time. Software first loads a set of configuration registers: a control word, a signed pixel count, a start address, the Z start value and Z slope, and a start value and slope for each of the red, green and blue channels. A start pulse then launches the span. On each following cycle the engine presents one pixel with its address, integer Z and integer colors, and then steps every accumulator by its slope. The pixel for index n therefore carries start + n·slope.

For each pixel the interpolated Z is compared with a stored depth value that the frame-buffer side places on `stored_z` in the same cycle. A three-bit condition field selects which of less, greater and equal count as a pass. The pixel write enable is raised only when the test passes and a 16-bit screen-door mask, indexed by the low four bits of the pixel index, has a 1 at that position. Z runs with either a 16-bit or a 24-bit integer part. Z stepping, color stepping and address stepping can each be frozen. A fast-Z mode drops the Z fraction. A pseudo-color mode blanks red and green.

Top module: `span_interp`

## Requirements
- R1: A start pulse in idle with a span count (register select 1, 13-bit two's complement) of zero or less produces no pixel; `done` is high for exactly the one cycle after the start edge and `busy` is low again in the cycle after that.
- R2: With a positive count N, `pix_valid` is high for exactly N consecutive cycles beginning the cycle after the start edge, `done` is high for the single cycle that follows, and a start pulse while busy has no effect on the pixel count.
- R3: With no hold and fast-Z off, pixel n carries Z integer = bits 35:12 of (Zstart + n·Zslope). Zstart is {int select 3 bits 23:0, frac select 4 bits 11:0} and Zslope is {select 5, select 6}. The sum wraps modulo 2^36 when control bit 20 is 1 (24-bit mode) and modulo 2^28 with integer bits 23:16 forced to zero when bit 20 is 0.
- R4: When control bit 21 (fast Z) is 1, the 12 fraction bits of the Z start, the Z slope and every Z sum are held at zero.
- R5: Each color channel (start at selects 7/8/9 for R/G/B, slopes at 10/11/12, 20 bits as 8.12 with a two's-complement slope) outputs bits 19:12 of clamp(start + n·slope, 0, 0xFFFFF), saturating instead of wrapping.
- R6: When control bit 19 (pseudo color) is 1, `pix_r` and `pix_g` read zero and blue is unaffected.
- R7: Control bit 16 freezes Z at its start value, bit 17 freezes all colors at their start values, and bit 18 freezes the address at its start value.
- R8: Control bits 24:22 enable the conditions equal (bit 24), greater (bit 23) and less (bit 22) between the pixel Z integer and `stored_z` (16 low bits only in 16-bit mode). The depth test passes when any enabled condition holds.
- R9: `pix_we` is high only during a valid pixel whose depth test passes and whose control mask bit (bits 15:0, indexed by pixel index mod 16) is 1.
- R10: `pix_addr` starts at the value of register select 2 and rises by one per pixel, modulo 2^24.
- R11: After reset `pix_valid`, `pix_we`, `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_sel | input | 4 | Configuration register select |
| cfg_data | input | 25 | Configuration write data |
| start | input | 1 | Launches a span when idle |
| stored_z | input | 24 | Stored depth for the pixel presented this cycle |
| pix_valid | output | 1 | A pixel is presented this cycle |
| pix_we | output | 1 | Pixel passes depth test and mask |
| pix_addr | output | 24 | Pixel address |
| pix_z | output | 24 | Interpolated Z integer part |
| pix_r | output | 8 | Red integer part |
| pix_g | output | 8 | Green integer part |
| pix_b | output | 8 | Blue integer part |
| busy | output | 1 | Span in progress or finishing |
| done | output | 1 | One-cycle end-of-span pulse |

## Verification
The address-step and Z-freeze properties assume that the control word is not rewritten while a span runs, since the hold bits are read live. The bench therefore writes every register only while the engine is idle and then pulses start. Stored depth is driven half a cycle before each pixel is sampled, and it is picked equal to, one above, one below or far from the expected Z so that all three comparison outcomes occur. Random spans mix negative, zero and positive counts, and color slopes large enough to reach both saturation limits.

// File: rtl/span_pkg.sv
package span_pkg;
    localparam int CNT_W = 13;
    localparam int ZI_W  = 24;
    localparam int ZI16  = 16;
    localparam int ZF_W  = 12;
    localparam int Z_W   = ZI_W + ZF_W;
    localparam int CI_W  = 8;
    localparam int CF_W  = 12;
    localparam int C_W   = CI_W + CF_W;
    localparam int NCH   = 3;
    localparam int ADR_W = 24;
    localparam int MSK_W = 16;
    localparam int IDX_W = $clog2(MSK_W);
    localparam int SEL_W = 4;

    typedef struct packed {
        logic [2:0]       cmp;        // [2]=eq [1]=gt [0]=lt
        logic             fast_z;
        logic             z24;
        logic             pseudo;
        logic             addr_hold;
        logic             col_hold;
        logic             z_hold;
        logic [MSK_W-1:0] mask;
    } ctl_t;

    localparam int CFG_W = $bits(ctl_t);

    localparam logic [SEL_W-1:0] RG_CTL = 4'd0;
    localparam logic [SEL_W-1:0] RG_CNT = 4'd1;
    localparam logic [SEL_W-1:0] RG_ADR = 4'd2;
    localparam logic [SEL_W-1:0] RG_ZI  = 4'd3;
    localparam logic [SEL_W-1:0] RG_ZF  = 4'd4;
    localparam logic [SEL_W-1:0] RG_ZSI = 4'd5;
    localparam logic [SEL_W-1:0] RG_ZSF = 4'd6;
    localparam logic [SEL_W-1:0] RG_CR  = 4'd7;
    localparam logic [SEL_W-1:0] RG_CG  = 4'd8;
    localparam logic [SEL_W-1:0] RG_CB  = 4'd9;
    localparam logic [SEL_W-1:0] RG_SR  = 4'd10;
    localparam logic [SEL_W-1:0] RG_SG  = 4'd11;
    localparam logic [SEL_W-1:0] RG_SB  = 4'd12;

    typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} st_e;

    // Saturating step of an unsigned 8.12 color by a signed 8.12 slope.
    function automatic logic [C_W-1:0] sat_step(input logic [C_W-1:0] c,
                                                input logic [C_W-1:0] d);
        logic [C_W+1:0] s;
        s = {2'b00, c} + {{2{d[C_W-1]}}, d};
        if (s[C_W+1])  return '0;
        else if (s[C_W]) return '1;
        else           return s[C_W-1:0];
    endfunction

    // Applies the precision and fast-Z restrictions to a Z quantity.
    function automatic logic [Z_W-1:0] z_fold(input logic [Z_W-1:0] v,
                                              input logic z24,
                                              input logic fast);
        logic [Z_W-1:0] r;
        r = v;
        if (!z24) r[Z_W-1:ZI16+ZF_W] = '0;
        if (fast) r[ZF_W-1:0] = '0;
        return r;
    endfunction
endpackage

// File: rtl/span_seq.sv
module span_seq
    import span_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] count,
    output logic             load,
    output logic             step,
    output logic             busy,
    output logic             done,
    output logic [IDX_W-1:0] idx
);
    st_e              st;
    logic [CNT_W-1:0] left;
    logic             positive;

    assign positive = !count[CNT_W-1] && (count != '0);
    assign load = start && (st == S_IDLE);
    assign step = (st == S_RUN);
    assign busy = (st != S_IDLE);
    assign done = (st == S_FIN);

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= S_IDLE;
            left <= '0;
            idx  <= '0;
        end else begin
            case (st)
                S_IDLE: if (start) begin
                    idx  <= '0;
                    left <= count;
                    st   <= positive ? S_RUN : S_FIN;
                end
                S_RUN: begin
                    idx  <= idx + IDX_W'(1);
                    left <= left - CNT_W'(1);
                    if (left == CNT_W'(1)) st <= S_FIN;
                end
                default: st <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/span_zpath.sv
module span_zpath
    import span_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic            step,
    input  logic            hold,
    input  logic            z24,
    input  logic            fast,
    input  logic [2:0]      cmp,
    input  logic [Z_W-1:0]  z_start,
    input  logic [Z_W-1:0]  z_slope,
    input  logic [ZI_W-1:0] stored_z,
    output logic [ZI_W-1:0] z_int,
    output logic            pass
);
    logic [Z_W-1:0]  acc;
    logic [ZI_W-1:0] ref_z;

    always_ff @(posedge clk) begin
        if (rst)                acc <= '0;
        else if (load)          acc <= z_fold(z_start, z24, fast);
        else if (step && !hold) acc <= z_fold(acc + z_fold(z_slope, z24, fast), z24, fast);
    end

    assign z_int = acc[Z_W-1:ZF_W];
    assign ref_z = z24 ? stored_z : {{(ZI_W-ZI16){1'b0}}, stored_z[ZI16-1:0]};
    assign pass  = (cmp[0] && (z_int <  ref_z)) ||
                   (cmp[1] && (z_int >  ref_z)) ||
                   (cmp[2] && (z_int == ref_z));
endmodule

// File: rtl/span_cpath.sv
module span_cpath
    import span_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic            step,
    input  logic            hold,
    input  logic [C_W-1:0]  c_start,
    input  logic [C_W-1:0]  c_slope,
    output logic [CI_W-1:0] c_int
);
    logic [C_W-1:0] acc;

    always_ff @(posedge clk) begin
        if (rst)                acc <= '0;
        else if (load)          acc <= c_start;
        else if (step && !hold) acc <= sat_step(acc, c_slope);
    end

    assign c_int = acc[C_W-1:CF_W];
endmodule

// File: rtl/span_interp.sv
module span_interp
    import span_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic [CFG_W-1:0] cfg_data,
    input  logic             start,
    input  logic [ZI_W-1:0]  stored_z,
    output logic             pix_valid,
    output logic             pix_we,
    output logic [ADR_W-1:0] pix_addr,
    output logic [ZI_W-1:0]  pix_z,
    output logic [CI_W-1:0]  pix_r,
    output logic [CI_W-1:0]  pix_g,
    output logic [CI_W-1:0]  pix_b,
    output logic             busy,
    output logic             done
);
    ctl_t             ctl_q;
    logic [CNT_W-1:0] cnt_q;
    logic [ADR_W-1:0] adr_q, addr_q;
    logic [ZI_W-1:0]  zi_q, zsi_q;
    logic [ZF_W-1:0]  zf_q, zsf_q;
    logic [C_W-1:0]   cst_q [NCH];
    logic [C_W-1:0]   csl_q [NCH];
    logic [CI_W-1:0]  col   [NCH];
    logic             load, step, pass;
    logic [IDX_W-1:0] idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            cnt_q <= '0;
            adr_q <= '0;
            zi_q  <= '0;
            zf_q  <= '0;
            zsi_q <= '0;
            zsf_q <= '0;
            for (int i = 0; i < NCH; i++) begin
                cst_q[i] <= '0;
                csl_q[i] <= '0;
            end
        end else if (cfg_we) begin
            case (cfg_sel)
                RG_CTL: ctl_q    <= cfg_data;
                RG_CNT: cnt_q    <= cfg_data[CNT_W-1:0];
                RG_ADR: adr_q    <= cfg_data[ADR_W-1:0];
                RG_ZI:  zi_q     <= cfg_data[ZI_W-1:0];
                RG_ZF:  zf_q     <= cfg_data[ZF_W-1:0];
                RG_ZSI: zsi_q    <= cfg_data[ZI_W-1:0];
                RG_ZSF: zsf_q    <= cfg_data[ZF_W-1:0];
                RG_CR:  cst_q[0] <= cfg_data[C_W-1:0];
                RG_CG:  cst_q[1] <= cfg_data[C_W-1:0];
                RG_CB:  cst_q[2] <= cfg_data[C_W-1:0];
                RG_SR:  csl_q[0] <= cfg_data[C_W-1:0];
                RG_SG:  csl_q[1] <= cfg_data[C_W-1:0];
                RG_SB:  csl_q[2] <= cfg_data[C_W-1:0];
                default: ;
            endcase
        end
    end

    span_seq u_seq (
        .clk(clk), .rst(rst), .start(start), .count(cnt_q),
        .load(load), .step(step), .busy(busy), .done(done), .idx(idx)
    );

    span_zpath u_z (
        .clk(clk), .rst(rst), .load(load), .step(step),
        .hold(ctl_q.z_hold), .z24(ctl_q.z24), .fast(ctl_q.fast_z), .cmp(ctl_q.cmp),
        .z_start({zi_q, zf_q}), .z_slope({zsi_q, zsf_q}),
        .stored_z(stored_z), .z_int(pix_z), .pass(pass)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        span_cpath u_c (
            .clk(clk), .rst(rst), .load(load), .step(step),
            .hold(ctl_q.col_hold), .c_start(cst_q[g]), .c_slope(csl_q[g]),
            .c_int(col[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)                          addr_q <= '0;
        else if (load)                    addr_q <= adr_q;
        else if (step && !ctl_q.addr_hold) addr_q <= addr_q + ADR_W'(1);
    end

    assign pix_valid = step;
    assign pix_we    = step && pass && ctl_q.mask[idx];
    assign pix_addr  = addr_q;
    assign pix_r     = ctl_q.pseudo ? '0 : col[0];
    assign pix_g     = ctl_q.pseudo ? '0 : col[1];
    assign pix_b     = col[2];
endmodule

// File: rtl/span_interp_chk.sv
module span_interp_chk
    import span_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             pix_valid,
    input logic             pix_we,
    input logic [ADR_W-1:0] pix_addr,
    input logic [ZI_W-1:0]  pix_z,
    input logic             busy,
    input logic             done,
    input ctl_t             ctl
);
    p_we_needs_valid_r9: assert property (@(posedge clk) disable iff (rst)
        pix_we |-> pix_valid);

    p_done_single_r2: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_no_pix_at_done_r1: assert property (@(posedge clk) disable iff (rst)
        done |-> !pix_valid && busy);

    p_done_after_run_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(pix_valid) |-> done);

    p_addr_step_r10: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && $past(pix_valid) && !ctl.addr_hold) |->
            pix_addr == $past(pix_addr) + ADR_W'(1));

    p_z_frozen_r7: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && $past(pix_valid) && ctl.z_hold) |-> $stable(pix_z));
endmodule

bind span_interp span_interp_chk u_chk (
    .clk(clk), .rst(rst), .pix_valid(pix_valid), .pix_we(pix_we),
    .pix_addr(pix_addr), .pix_z(pix_z), .busy(busy), .done(done), .ctl(ctl_q)
);

// File: tb/sim_span_interp.sv
module sim_span_interp;
    logic        clk = 0, rst = 1;
    logic        cfg_we = 0;
    logic [3:0]  cfg_sel = 0;
    logic [24:0] cfg_data = 0;
    logic        start = 0;
    logic [23:0] stored_z = 0;
    logic        pix_valid, pix_we, busy, done;
    logic [23:0] pix_addr, pix_z;
    logic [7:0]  pix_r, pix_g, pix_b;

    int n_chk = 0, n_bad = 0;

    // bench-side copy of the programmed span
    logic [15:0] b_mask;
    logic        b_zh, b_ch, b_ah, b_ps, b_z24, b_fz;
    logic [2:0]  b_cmp;
    logic [23:0] b_adr, b_zi, b_zsi;
    logic [11:0] b_zf, b_zsf;
    logic [19:0] b_cs [3];
    logic [19:0] b_sl [3];

    span_interp u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
        .start(start), .stored_z(stored_z), .pix_valid(pix_valid), .pix_we(pix_we),
        .pix_addr(pix_addr), .pix_z(pix_z), .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
        .busy(busy), .done(done)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [3:0] sel, input logic [24:0] d);
        cfg_we = 1; cfg_sel = sel; cfg_data = d;
        @(negedge clk);
        cfg_we = 0;
    endtask

    function automatic logic [35:0] zf_b(input logic [35:0] v);
        logic [35:0] r = v;
        if (!b_z24) r[35:28] = '0;
        if (b_fz) r[11:0] = '0;
        return r;
    endfunction

    function automatic logic [23:0] exp_z(input int n);
        logic [35:0] a = zf_b({b_zi, b_zf});
        logic [35:0] s = zf_b({b_zsi, b_zsf});
        int m = b_zh ? 0 : n;
        return zf_b(a + s * 36'(m)) >> 12;
    endfunction

    function automatic logic [7:0] exp_c(input int ch, input int n);
        longint s = b_sl[ch][19] ? longint'(b_sl[ch]) - 1048576 : longint'(b_sl[ch]);
        int m = b_ch ? 0 : n;
        longint v = longint'(b_cs[ch]) + longint'(m) * s;
        if (v < 0) v = 0;
        if (v > 1048575) v = 1048575;
        return 8'(v >>> 12);
    endfunction

    task automatic defaults();
        b_mask = 16'hFFFF; b_zh = 0; b_ch = 0; b_ah = 0; b_ps = 0; b_z24 = 1; b_fz = 0;
        b_cmp = 3'b001; b_adr = 24'h000100; b_zi = 24'h000400; b_zf = 0;
        b_zsi = 24'h000002; b_zsf = 12'h400;
        for (int i = 0; i < 3; i++) begin b_cs[i] = 20'h10000 * (i + 1); b_sl[i] = 20'h00800; end
    endtask

    task automatic run_span(input int npix, input bit poke);
        logic [23:0] ez, sz, rz;
        bit pass;
        wr(4'd0, {b_cmp, b_fz, b_z24, b_ps, b_ah, b_ch, b_zh, b_mask});
        wr(4'd1, 25'(13'(npix)));
        wr(4'd2, 25'(b_adr));
        wr(4'd3, 25'(b_zi));
        wr(4'd4, 25'(b_zf));
        wr(4'd5, 25'(b_zsi));
        wr(4'd6, 25'(b_zsf));
        for (int i = 0; i < 3; i++) begin
            wr(4'(7 + i), 25'(b_cs[i]));
            wr(4'(10 + i), 25'(b_sl[i]));
        end
        start = 1;
        @(negedge clk);
        start = 0;
        if (npix <= 0) begin
            #1;
            chk(pix_valid == 0, "R1 valid on empty span", pix_valid, 0);
            chk(done == 1, "R1 done after empty span", done, 1);
            @(negedge clk); #1;
            chk(done == 0 && busy == 0, "R1 idle after empty span", {done, busy}, 0);
            @(negedge clk);
            return;
        end
        for (int k = 0; k < npix; k++) begin
            start = poke && (k == 1);
            ez = exp_z(k);
            case ($urandom_range(0, 3))
                0: sz = ez;
                1: sz = ez + 24'd1;
                2: sz = ez - 24'd1;
                default: sz = 24'($urandom);
            endcase
            stored_z = sz;
            #1;
            rz = b_z24 ? sz : {8'h0, sz[15:0]};
            pass = (b_cmp[0] && ez < rz) || (b_cmp[1] && ez > rz) || (b_cmp[2] && ez == rz);
            chk(pix_valid == 1, "R2 valid during span", pix_valid, 1);
            chk(pix_addr == b_adr + (b_ah ? 24'd0 : 24'(k)), b_ah ? "R7 address hold" : "R10 address",
                pix_addr, b_adr + (b_ah ? 24'd0 : 24'(k)));
            chk(pix_z == ez, b_zh ? "R7 Z hold" : (b_fz ? "R4 fast Z" : "R3 Z value"), pix_z, ez);
            chk(pix_r == (b_ps ? 8'h0 : exp_c(0, k)), b_ps ? "R6 red blank" : "R5 red",
                pix_r, b_ps ? 8'h0 : exp_c(0, k));
            chk(pix_g == (b_ps ? 8'h0 : exp_c(1, k)), b_ps ? "R6 green blank" : "R5 green",
                pix_g, b_ps ? 8'h0 : exp_c(1, k));
            chk(pix_b == exp_c(2, k), b_ch ? "R7 color hold" : "R5 blue", pix_b, exp_c(2, k));
            chk(pix_we == (pass && b_mask[k % 16]), pass ? "R9 mask gate" : "R8 depth test",
                pix_we, pass && b_mask[k % 16]);
            @(negedge clk);
        end
        start = 0;
        #1;
        chk(pix_valid == 0, "R2 span length", pix_valid, 0);
        chk(done == 1, "R2 done pulse", done, 1);
        @(negedge clk); #1;
        chk(done == 0 && busy == 0, "R2 return to idle", {done, busy}, 0);
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        #1;
        chk(pix_valid == 0 && pix_we == 0, "R11 reset outputs", {pix_valid, pix_we}, 0);
        chk(busy == 0 && done == 0, "R11 reset status", {busy, done}, 0);
        rst = 0;
        @(negedge clk);

        defaults(); run_span(8, 0);
        defaults(); run_span(0, 0);
        defaults(); run_span(-5, 0);
        defaults(); b_cs[0] = 20'hFE000; b_sl[0] = 20'h00800;
                    b_cs[1] = 20'h01000; b_sl[1] = 20'hFF800; run_span(10, 0);   // R5 both limits
        defaults(); b_ps = 1; run_span(5, 0);                                    // R6
        defaults(); b_zh = 1; run_span(6, 0);                                    // R7
        defaults(); b_ch = 1; run_span(6, 0);
        defaults(); b_ah = 1; run_span(6, 0);
        defaults(); b_zf = 12'h800; b_zsi = 0; b_zsf = 12'h900; run_span(6, 0);  // R3 carry
        defaults(); b_zf = 12'h800; b_zsi = 0; b_zsf = 12'h900; b_fz = 1; run_span(6, 0); // R4
        defaults(); b_z24 = 0; b_zi = 24'h12FFFE; b_zsi = 1; b_zsf = 0; run_span(5, 0); // R3 wrap
        defaults(); b_adr = 24'hFFFFFE; run_span(4, 0);                           // R10 wrap
        for (int c = 0; c < 8; c++) begin defaults(); b_cmp = 3'(c); run_span(6, 0); end // R8
        defaults(); b_mask = 16'hA5C3; run_span(20, 0);                           // R9
        defaults(); run_span(6, 1);                                               // R2 start while busy

        for (int t = 0; t < 40; t++) begin
            b_mask = 16'($urandom); b_cmp = 3'($urandom);
            b_zh = ($urandom_range(0, 7) == 0); b_ch = ($urandom_range(0, 7) == 0);
            b_ah = ($urandom_range(0, 7) == 0); b_ps = ($urandom_range(0, 3) == 0);
            b_z24 = 1'($urandom); b_fz = ($urandom_range(0, 3) == 0);
            b_adr = 24'($urandom); b_zi = 24'($urandom); b_zf = 12'($urandom);
            b_zsi = 24'(int'($urandom_range(0, 64)) - 32); b_zsf = 12'($urandom);
            for (int i = 0; i < 3; i++) begin
                b_cs[i] = 20'($urandom);
                b_sl[i] = 20'(int'($urandom_range(0, 24576)) - 12288);
            end
            run_span(int'($urandom_range(0, 23)) - 3, 0);
        end

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(20 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule